// File: doc/BRIEF.md
# Multi-Rail Power-On Reset Sequencer

This block merges a set of supply-good levels, one per monitored rail, into a single main reset. Each level comes from an analog detector and is high when its rail is above the trip point. The block synchronizes every level on its own. It holds the device in reset and keeps outputs and configuration registers tri-stated until all rails are good. It then waits a release delay, releases reset, drops the tri-state enable and emits a one-cycle configuration-start strobe.

A ramp watchdog measures how long the rails spend partly good, that is with some rails up and some still down. If that time reaches a limit, the block enters a sticky fault. Reset stays asserted, the pins stay tri-stated and configuration never starts until the asynchronous power-on input is pulled low. The release delay has two lengths. The standard length is the default; a shorter one can be selected for fast wake-up. If a rail is lost after release, reset and tri-state return at once and the whole sequence starts again.

Top module: `multi_rail_por`

## Requirements
- R1: While `por_n` is low, `rst_hold`=1, `hiz_en`=1, `cfg_start`=0 and `ramp_fault`=0.
- R2: Each bit of `rail_ok` passes through a two-flop synchronizer. `rst_hold` stays 1 while any rail is low. With rails rising at different times, the release timing is counted from the last one.
- R3: With `fast_sel`=0, `rst_hold` and `hiz_en` fall on rising edge STD_DELAY+3, counted from the first edge at which the last rail input is sampled high. They stay 1 on the edge before.
- R4: `fast_sel`=1 gives FAST_DELAY+3 instead. `fast_sel` is captured when the delay begins, and a change during the delay has no effect on the release edge.
- R5: `cfg_start` is 1 for exactly one cycle: the cycle in which `rst_hold` and `hiz_en` first read 0.
- R6: If a rail drops during the delay, the delay restarts from zero. Release then follows STD_DELAY+3 edges after the rail is back.
- R7: If a rail drops after release, `rst_hold` and `hiz_en` return to 1 two edges after the drop is first sampled, with no further edge needed. When the rail returns, the full sequence runs again and issues a new `cfg_start`.
- R8: Cycles in which the synchronized rails are partly good are counted. When RAMP_LIMIT such cycles occur, `ramp_fault` rises. If the first rail rises at edge 1, the last rail rising at edge RAMP_LIMIT still releases normally, while rising at edge RAMP_LIMIT+1 gives `ramp_fault` at edge RAMP_LIMIT+2.
- R9: `ramp_fault` is sticky. While it is 1, `rst_hold` and `hiz_en` stay 1 and `cfg_start` stays 0, even with all rails good. Only `por_n` clears it.
- R10: If a rail loss is seen on the same edge on which the delay would complete, the loss wins: there is no release and no strobe on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-cycle reset |
| rail_ok | input | N_RAILS | Per-rail good levels from the supply detectors (asynchronous) |
| fast_sel | input | 1 | 1 selects the short release delay |
| rst_hold | output | 1 | Main reset, high while the device is held |
| hiz_en | output | 1 | Tri-state enable for outputs and configuration registers |
| cfg_start | output | 1 | One-cycle strobe that starts configuration |
| ramp_fault | output | 1 | Sticky ramp-timeout flag |

## Verification
Two functions can fall on the same edge: completion of the release delay, and the loss of a rail seen by the synchronizer. The bench drops one rail exactly STD_DELAY edges after all rails rose, so the synchronized low reaches the state logic on the release edge. It then expects reset still held with no strobe on that edge, and a strobe one full delay after the rail returns. The ramp limit is probed the same way, with the last rail arriving one edge before and one edge after the window closes. The scoreboard compares the edge of each strobe and each fault against the edge predicted by the driver.

// File: rtl/multi_rail_por.sv
module multi_rail_por #(
  parameter int N_RAILS    = 3,
  parameter int STD_DELAY  = 1024,
  parameter int FAST_DELAY = 16,
  parameter int RAMP_LIMIT = 4096
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_RAILS-1:0] rail_ok,
  input  logic               fast_sel,
  output logic               rst_hold,
  output logic               hiz_en,
  output logic               cfg_start,
  output logic               ramp_fault
);

  localparam int MAXD = (STD_DELAY > FAST_DELAY) ? STD_DELAY : FAST_DELAY;
  localparam int DW   = $clog2(MAXD) + 1;
  localparam int RW   = $clog2(RAMP_LIMIT) + 1;

  typedef enum logic [1:0] {ST_WAIT, ST_DELAY, ST_RUN, ST_FAULT} state_t;

  state_t             st;
  logic [N_RAILS-1:0] meta_q, good_q;
  logic [DW-1:0]      dly_q;
  logic [RW-1:0]      ramp_q;
  logic               fast_q, start_q;

  wire all_good = &good_q;
  wire any_good = |good_q;
  wire [DW-1:0] dly_last = fast_q ? DW'(FAST_DELAY - 1) : DW'(STD_DELAY - 1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= '0;
      good_q <= '0;
    end else begin
      meta_q <= rail_ok;
      good_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= ST_WAIT;
      dly_q   <= '0;
      ramp_q  <= '0;
      fast_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        ST_WAIT: begin
          dly_q <= '0;
          if (all_good) begin
            st     <= ST_DELAY;
            fast_q <= fast_sel;
            ramp_q <= '0;
          end else if (any_good) begin
            if (ramp_q == RW'(RAMP_LIMIT - 1)) st <= ST_FAULT;
            else ramp_q <= ramp_q + 1'b1;
          end else begin
            ramp_q <= '0;
          end
        end
        ST_DELAY: begin
          if (!all_good) begin
            st     <= ST_WAIT;
            dly_q  <= '0;
            ramp_q <= '0;
          end else if (dly_q == dly_last) begin
            st      <= ST_RUN;
            dly_q   <= '0;
            start_q <= 1'b1;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (!all_good) begin
            st     <= ST_WAIT;
            ramp_q <= '0;
          end
        end
        default: st <= ST_FAULT;
      endcase
    end
  end

  assign rst_hold   = !((st == ST_RUN) && all_good);
  assign hiz_en     = rst_hold;
  assign cfg_start  = start_q && all_good;
  assign ramp_fault = (st == ST_FAULT);

endmodule

module multi_rail_por_chk #(
  parameter int N_RAILS = 3
) (
  input logic               clk,
  input logic               por_n,
  input logic [N_RAILS-1:0] rail_ok,
  input logic               rst_hold,
  input logic               hiz_en,
  input logic               cfg_start,
  input logic               ramp_fault
);

  p_low_rail_holds_r2: assert property (@(posedge clk) disable iff (!por_n)
    $past(!(&rail_ok), 2) |-> rst_hold);

  p_strobe_one_cycle_r5: assert property (@(posedge clk) disable iff (!por_n)
    cfg_start |=> !cfg_start);

  p_strobe_released_r5: assert property (@(posedge clk) disable iff (!por_n)
    cfg_start |-> (!rst_hold && !hiz_en));

  p_release_has_strobe_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_hold) |-> cfg_start);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    ramp_fault |=> ramp_fault);

  p_fault_holds_r9: assert property (@(posedge clk) disable iff (!por_n)
    ramp_fault |-> (rst_hold && hiz_en && !cfg_start));

endmodule

bind multi_rail_por multi_rail_por_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk(clk), .por_n(por_n), .rail_ok(rail_ok), .rst_hold(rst_hold),
  .hiz_en(hiz_en), .cfg_start(cfg_start), .ramp_fault(ramp_fault)
);

// File: tb/multi_rail_por_test.sv
module multi_rail_por_test;
  localparam int N = 3, SD = 40, FD = 6, RL = 30;

  logic clk = 1'b0, por_n = 1'b0, fast = 1'b0;
  logic [N-1:0] rail = '0;
  logic rst_hold, hiz_en, cfg_start, ramp_fault;

  multi_rail_por #(.N_RAILS(N), .STD_DELAY(SD), .FAST_DELAY(FD), .RAMP_LIMIT(RL)) uut (
    .clk(clk), .por_n(por_n), .rail_ok(rail), .fast_sel(fast),
    .rst_hold(rst_hold), .hiz_en(hiz_en), .cfg_start(cfg_start), .ramp_fault(ramp_fault));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; int at; string req; } ev_t;
  ev_t exp_q[$];

  task automatic expect_ev(int kind, int at, string req);
    exp_q.push_back('{kind, at, req});
  endtask

  task automatic take(int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        errors++;
        $display("FAIL %s event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  logic fault_d = 1'b0;
  always @(negedge clk) begin
    if (por_n) begin
      if (cfg_start) take(1);
      if (ramp_fault && !fault_d) take(2);
      fault_d = ramp_fault;
    end else fault_d = 1'b0;
  end

  task automatic chk(string req, string what, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at cycle %0d", req, what, act, exp_v, cyc);
    end
  endtask

  task automatic at(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic por_cycle();
    @(negedge clk);
    por_n = 1'b0; rail = '0; fast = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rst_hold", rst_hold, 1'b1);
    chk("R1", "hiz_en", hiz_en, 1'b1);
    chk("R1", "cfg_start", cfg_start, 1'b0);
    chk("R1", "ramp_fault", ramp_fault, 1'b0);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    int c0, c;
    // R3 / R5: all rails together, standard delay
    por_cycle();
    c0 = cyc; rail = '1;
    expect_ev(1, c0 + SD + 3, "R3");
    at(c0 + SD + 2);
    chk("R3", "rst_hold before release", rst_hold, 1'b1);
    chk("R3", "hiz_en before release", hiz_en, 1'b1);
    at(c0 + SD + 3);
    chk("R3", "rst_hold at release", rst_hold, 1'b0);
    chk("R5", "hiz_en at release", hiz_en, 1'b0);
    at(c0 + SD + 4);
    chk("R5", "cfg_start after pulse", cfg_start, 1'b0);
    // R7: drop after release
    c = cyc; rail[1] = 1'b0;
    at(c + 1);
    chk("R7", "rst_hold one edge after drop", rst_hold, 1'b0);
    at(c + 2);
    chk("R7", "rst_hold reasserted", rst_hold, 1'b1);
    chk("R7", "hiz_en reasserted", hiz_en, 1'b1);
    at(c + 3); rail[1] = 1'b1;
    expect_ev(1, c + 3 + SD + 3, "R7");
    at(c + 3 + SD + 4);

    // R2: staggered rails
    por_cycle();
    c0 = cyc; rail[0] = 1'b1;
    at(c0 + 5); rail[2] = 1'b1;
    at(c0 + 10); rail[1] = 1'b1;
    expect_ev(1, c0 + 10 + SD + 3, "R2");
    at(c0 + 10 + SD + 2);
    chk("R2", "rst_hold held until last rail plus delay", rst_hold, 1'b1);
    at(c0 + 10 + SD + 4);

    // R4: fast delay
    por_cycle();
    fast = 1'b1; c0 = cyc; rail = '1;
    expect_ev(1, c0 + FD + 3, "R4");
    at(c0 + FD + 4);
    chk("R4", "rst_hold after fast release", rst_hold, 1'b0);

    // R4: fast_sel change during delay ignored
    por_cycle();
    c0 = cyc; rail = '1;
    at(c0 + 10); fast = 1'b1;
    expect_ev(1, c0 + SD + 3, "R4");
    at(c0 + FD + 3);
    chk("R4", "rst_hold with late fast_sel", rst_hold, 1'b1);
    at(c0 + SD + 4);

    // R6: drop during delay
    por_cycle();
    c0 = cyc; rail = '1;
    at(c0 + 10); rail[1] = 1'b0;
    at(c0 + 12); rail[1] = 1'b1;
    expect_ev(1, c0 + 12 + SD + 3, "R6");
    at(c0 + SD + 3);
    chk("R6", "rst_hold after restarted delay", rst_hold, 1'b1);
    at(c0 + 12 + SD + 4);

    // R10: loss seen on the completion edge
    por_cycle();
    c0 = cyc; rail = '1;
    at(c0 + SD); rail[2] = 1'b0;
    at(c0 + SD + 2); rail[2] = 1'b1;
    at(c0 + SD + 3);
    chk("R10", "rst_hold on collision edge", rst_hold, 1'b1);
    chk("R10", "cfg_start on collision edge", cfg_start, 1'b0);
    expect_ev(1, c0 + SD + 2 + SD + 3, "R10");
    at(c0 + 2 * SD + 6);

    // R8: last rail just inside the window
    por_cycle();
    c0 = cyc; rail[0] = 1'b1;
    at(c0 + RL - 1); rail = '1;
    expect_ev(1, c0 + RL - 1 + SD + 3, "R8");
    at(c0 + RL + SD + 3);
    chk("R8", "ramp_fault inside window", ramp_fault, 1'b0);

    // R8 / R9: last rail one edge late
    por_cycle();
    c0 = cyc; rail[0] = 1'b1;
    expect_ev(2, c0 + RL + 2, "R8");
    at(c0 + RL); rail = '1;
    at(c0 + RL + 2);
    chk("R8", "ramp_fault at limit", ramp_fault, 1'b1);
    at(c0 + RL + SD + 12);
    chk("R9", "ramp_fault sticky", ramp_fault, 1'b1);
    chk("R9", "rst_hold in fault", rst_hold, 1'b1);
    chk("R9", "hiz_en in fault", hiz_en, 1'b1);
    por_cycle();
    chk("R9", "ramp_fault cleared by por_n", ramp_fault, 1'b0);
    c0 = cyc; rail = '1;
    expect_ev(1, c0 + SD + 3, "R9");
    at(c0 + SD + 5);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending events actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule